// File: doc/BRIEF.md
# Instruction Fetch and Display Datapath

This block is the fetch stage of a small 16-bit processor. It holds a 16-bit program counter, an incrementer, a selector that picks the next program counter value, a combinational instruction ROM of 256 16-bit words, an instruction register and a display register. A small sequencer steps the datapath. First it loads the word at the current program counter into the instruction register and advances the counter. Then it places the instruction register on the internal bus and copies the bus into the display register.

The internal bus carries the instruction register value while the sequencer drives it onto the bus. At all other times it carries the external jump value. The program counter has two commands: load from the bus, or load its own value plus one. Its register enable is the OR of the two commands, and the selector uses the bus-load command to choose between them. The sequencer never issues the bus-load command, so the jump value only reaches the counter's input path and never changes its value. A parameter selects a longer sequence that fetches and displays a second word after the first.

Top module: `fetch_display_top`

## Requirements
- R1: While `rst` is high at a clock edge, `pc_o`, `ir_o` and `disp_o` become 0x0000 and the sequencer returns to its first load state.
- R2: On the second clock edge after reset is released, `ir_o` takes the ROM word at address 0 and `pc_o` becomes 1.
- R3: On the third clock edge after reset is released, `disp_o` takes the same word as `ir_o`, carried over the internal bus.
- R4: With `TWO_FETCH=0`, the block then stays in its transfer state: `pc_o` stays 1 and `ir_o` and `disp_o` stay at ROM word 0 for as long as reset is low.
- R5: The ROM is indexed by `pc_o[7:0]`. Word i of the `PRELOAD` parameter sits at bits [16*i+15:16*i]. Addresses at or above `PRELOAD_N` read 0x0000.
- R6: Values on `jump_bus` have no effect on `pc_o`, `ir_o` or `disp_o`, because the sequencer never issues the bus-to-PC command.
- R7: With `TWO_FETCH=1`, the fourth clock edge after reset release loads ROM word 1 into `ir_o` and sets `pc_o` to 2. The fifth edge copies word 1 into `disp_o`. After that, all three outputs hold.
- R8: Each program counter load done by the sequencer adds exactly one, computed as PC + 0 + carry-in 1. The increment and bus-load commands are never active together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| jump_bus | input | 16 | External value driven on the internal bus for jumps |
| pc_o | output | 16 | Program counter |
| ir_o | output | 16 | Instruction register |
| disp_o | output | 16 | Display register |

## Verification
The bench builds two copies of the block. The first uses the defaults: single fetch, with four preload words at addresses 0 to 3. The second uses `TWO_FETCH=1` and a different two-word preload, which makes the second fetch reachable and shows that the ROM contents follow the parameter. The jump bus is changed on every cycle in both copies to show it has no effect, and a second reset in the middle of the run checks that the whole sequence restarts.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    ST_LOAD1 = 2'd0,
    ST_XFER1 = 2'd1,
    ST_LOAD2 = 2'd2,
    ST_XFER2 = 2'd3
  } seq_state_t;

  typedef struct packed {
    logic ir_load;
    logic pc_inc;
    logic bus2pc;
    logic ir2bus;
    logic bus2disp;
  } fetch_cmd_t;

  function automatic fetch_cmd_t decode_state(seq_state_t s);
    fetch_cmd_t c;
    c = '0;
    case (s)
      ST_LOAD1, ST_LOAD2: begin
        c.ir_load = 1'b1;
        c.pc_inc  = 1'b1;
      end
      default: begin
        c.ir2bus   = 1'b1;
        c.bus2disp = 1'b1;
      end
    endcase
    return c;
  endfunction

endpackage

// File: rtl/fetch_rom.sv
module fetch_rom #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int PRELOAD_N = 4,
  parameter logic [PRELOAD_N*DATA_W-1:0] PRELOAD = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] word
);
  localparam int DEPTH = 1 << ADDR_W;

  always_comb begin
    word = '0;
    for (int i = 0; i < PRELOAD_N; i++) begin
      if (i < DEPTH && addr == i[ADDR_W-1:0]) word = PRELOAD[i*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/pc_unit.sv
module pc_unit #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_inc,
  input  logic              cmd_bus2pc,
  input  logic [DATA_W-1:0] bus_val,
  output logic [DATA_W-1:0] pc
);
  logic [DATA_W-1:0] pc_plus1;
  logic [DATA_W-1:0] pc_next;
  logic              pc_ce;

  function automatic logic [DATA_W-1:0] add_cin(logic [DATA_W-1:0] a,
                                                logic [DATA_W-1:0] b,
                                                logic              cin);
    return a + b + {{(DATA_W-1){1'b0}}, cin};
  endfunction

  assign pc_plus1 = add_cin(pc, '0, 1'b1);
  assign pc_next  = cmd_bus2pc ? bus_val : pc_plus1;
  assign pc_ce    = cmd_bus2pc | cmd_inc;

  always_ff @(posedge clk) begin
    if (rst)        pc <= '0;
    else if (pc_ce) pc <= pc_next;
  end

  // R8: commands never overlap
  a_r8_cmds_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(cmd_inc && cmd_bus2pc));

  // R8: an increment advances the counter by exactly one
  a_r8_pc_step: assert property (@(posedge clk) disable iff (rst)
    (cmd_inc && !cmd_bus2pc) |=> pc == $past(pc) + 1'b1);

  // R6: without a command the counter holds
  a_r6_pc_hold: assert property (@(posedge clk) disable iff (rst)
    (!cmd_inc && !cmd_bus2pc) |=> $stable(pc));
endmodule

// File: rtl/fetch_sequencer.sv
module fetch_sequencer
  import fetch_pkg::*;
#(
  parameter bit TWO_FETCH = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  output fetch_cmd_t cmd
);
  seq_state_t state, state_nx;
  logic       at_final;

  generate
    if (TWO_FETCH) begin : g_two
      always_comb begin
        case (state)
          ST_LOAD1: state_nx = ST_XFER1;
          ST_XFER1: state_nx = ST_LOAD2;
          ST_LOAD2: state_nx = ST_XFER2;
          default:  state_nx = ST_XFER2;
        endcase
      end
      assign at_final = (state == ST_XFER2);
    end else begin : g_one
      always_comb begin
        case (state)
          ST_LOAD1: state_nx = ST_XFER1;
          default:  state_nx = ST_XFER1;
        endcase
      end
      assign at_final = (state == ST_XFER1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_LOAD1;
      cmd   <= '0;
    end else begin
      state <= state_nx;
      cmd   <= decode_state(state);
    end
  end

  // R4: the final transfer state holds forever
  a_r4_final_holds: assert property (@(posedge clk) disable iff (rst)
    at_final |=> at_final);

  // R8: the bus-to-PC command is never issued by this sequence
  a_r8_no_bus2pc: assert property (@(posedge clk) disable iff (rst)
    !cmd.bus2pc);
endmodule

// File: rtl/fetch_display_top.sv
module fetch_display_top
  import fetch_pkg::*;
#(
  parameter int DATA_W    = WORD_W,
  parameter int ADDR_W    = 8,
  parameter bit TWO_FETCH = 1'b0,
  parameter int PRELOAD_N = 4,
  parameter logic [PRELOAD_N*DATA_W-1:0] PRELOAD =
    {16'h7E42, 16'hC0DE, 16'h5A3C, 16'h1B81}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] jump_bus,
  output logic [DATA_W-1:0] pc_o,
  output logic [DATA_W-1:0] ir_o,
  output logic [DATA_W-1:0] disp_o
);
  fetch_cmd_t        cmd;
  logic [DATA_W-1:0] rom_word;
  logic [DATA_W-1:0] bus_val;

  fetch_sequencer #(.TWO_FETCH(TWO_FETCH)) seq_i (
    .clk (clk),
    .rst (rst),
    .cmd (cmd)
  );

  pc_unit #(.DATA_W(DATA_W)) pcu_i (
    .clk        (clk),
    .rst        (rst),
    .cmd_inc    (cmd.pc_inc),
    .cmd_bus2pc (cmd.bus2pc),
    .bus_val    (bus_val),
    .pc         (pc_o)
  );

  fetch_rom #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PRELOAD_N (PRELOAD_N),
    .PRELOAD   (PRELOAD)
  ) rom_i (
    .addr (pc_o[ADDR_W-1:0]),
    .word (rom_word)
  );

  assign bus_val = cmd.ir2bus ? ir_o : jump_bus;

  always_ff @(posedge clk) begin
    if (rst)              ir_o <= '0;
    else if (cmd.ir_load) ir_o <= rom_word;
  end

  always_ff @(posedge clk) begin
    if (rst)               disp_o <= '0;
    else if (cmd.bus2disp) disp_o <= bus_val;
  end

  // R2: instruction register captures the ROM word at the load
  a_r2_ir_capture: assert property (@(posedge clk) disable iff (rst)
    cmd.ir_load |=> ir_o == $past(rom_word));

  // R3: display register captures the bus value at the transfer
  a_r3_disp_capture: assert property (@(posedge clk) disable iff (rst)
    cmd.bus2disp |=> disp_o == $past(bus_val));

  // R3: the transfer drives the instruction register onto the bus
  a_r3_bus_source: assert property (@(posedge clk) disable iff (rst)
    cmd.ir2bus |-> bus_val == ir_o);

  // R6: display register untouched outside a transfer
  a_r6_disp_hold: assert property (@(posedge clk) disable iff (rst)
    !cmd.bus2disp |=> $stable(disp_o));
endmodule

// File: tb/fetch_display_top_tb_top.sv
`timescale 1ns/1ps
module fetch_display_top_tb_top;
  localparam logic [15:0] A0 = 16'h1B81, A1 = 16'h5A3C;
  localparam logic [15:0] B0 = 16'hBEEF, B1 = 16'h0F35;

  typedef struct {
    logic [15:0] pc1, ir1, d1, pc2, ir2, d2;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] jump_bus = 16'h0000;
  logic [15:0] pc1, ir1, d1, pc2, ir2, d2;
  logic        run = 1'b0;
  logic        done = 1'b0;
  int          n_cmp = 0;
  int          n_bad = 0;
  exp_t        sb[$];

  always #2 clk = ~clk;

  fetch_display_top dut_i (
    .clk(clk), .rst(rst), .jump_bus(jump_bus),
    .pc_o(pc1), .ir_o(ir1), .disp_o(d1)
  );

  fetch_display_top #(
    .TWO_FETCH(1'b1), .PRELOAD_N(2), .PRELOAD({B1, B0})
  ) dut2_i (
    .clk(clk), .rst(rst), .jump_bus(jump_bus),
    .pc_o(pc2), .ir_o(ir2), .disp_o(d2)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // driver: expected outputs after edge k following reset release
  task automatic push_run(int cycles);
    for (int k = 1; k <= cycles; k++) begin
      exp_t e;
      e.pc1 = (k >= 2) ? 16'd1 : 16'd0;
      e.ir1 = (k >= 2) ? A0 : 16'h0000;
      e.d1  = (k >= 3) ? A0 : 16'h0000;
      e.pc2 = (k >= 4) ? 16'd2 : (k >= 2) ? 16'd1 : 16'd0;
      e.ir2 = (k >= 4) ? B1 : (k >= 2) ? B0 : 16'h0000;
      e.d2  = (k >= 5) ? B1 : (k >= 3) ? B0 : 16'h0000;
      e.tag = (k == 2) ? "R2" : (k == 3) ? "R3" : (k <= 5) ? "R7" : "R4_R6";
      sb.push_back(e);
    end
  endtask

  // monitor: pops one expected item per cycle, between edges
  always @(negedge clk) begin
    if (run && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk({e.tag, " R8 pc"},   pc1, e.pc1);
      chk({e.tag, " ir"},      ir1, e.ir1);
      chk({e.tag, " disp"},    d1,  e.d1);
      chk({e.tag, " R7 pc2"},  pc2, e.pc2);
      chk({e.tag, " R5 ir2"},  ir2, e.ir2);
      chk({e.tag, " R7 disp2"}, d2, e.d2);
    end
  end

  // jump bus toggles every cycle: R6 says it has no effect
  initial begin
    forever begin
      @(negedge clk);
      #1 jump_bus = jump_bus * 16'd37 + 16'h1F3B;
    end
  end

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 pc", pc1, 16'h0000);
    chk("R1 ir", ir1, 16'h0000);
    chk("R1 disp", d1, 16'h0000);
    chk("R1 pc2", pc2, 16'h0000);
    chk("R1 disp2", d2, 16'h0000);
    rst = 1'b0;
    @(posedge clk);
    #0.5 run = 1'b1;
  endtask

  initial begin
    push_run(14);
    do_reset();
    wait (sb.size() == 0);
    @(negedge clk);
    run = 1'b0;
    push_run(8);
    do_reset();
    wait (sb.size() == 0);
    @(negedge clk);
    run = 1'b0;
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 5000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule